// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that retires exactly one instruction on every rising clock edge. Each instruction is fetched, decoded, executed and written back in one clock period. The core holds a program counter, a 32 x 32-bit register file, the immediate extenders, an arithmetic unit and a decoder. The decoder drives the datapath through a small bundle of control strobes.

The core recognises six instructions: wrapping add and subtract between registers, bitwise OR with a zero-padded 16-bit constant, word load, word store, and a conditional relative branch taken when two registers match. Any other encoding retires as a no-op.

Instruction memory sits outside the core and is read combinationally from the program counter. Data memory also sits outside the core: it is read combinationally from the computed address and written on the clock edge while the write strobe is high. Both memories are addressed in bytes, and the word index is taken from address bits 31:2.

Top module: `lite_core`

## Requirements
- R1: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and the 16-bit constant [15:0]. Every instruction other than a branch advances `instrAddr` by 4 on each clock edge.
- R2: A synchronous active-high `rst` loads 0 into the program counter at the clock edge where it is sampled high, and blocks register and memory writes.
- R3: Opcode 0x00 with funct 0x21 writes rs + rt into rd, and funct 0x23 writes rs - rt into rd. Both wrap modulo 2^32 and raise no trap.
- R4: Opcode 0x0D writes rs OR the zero-extended 16-bit constant into rt.
- R5: Opcode 0x23 writes the data word at byte address rs + sign-extended constant into rt.
- R6: Opcode 0x2B writes rt to the data word at byte address rs + sign-extended constant and changes no register. `dataWe` is high only for this opcode.
- R7: Opcode 0x04 compares rs with rt. When they are equal, the next PC is PC + 4 + (sign-extended constant << 2). Otherwise it is PC + 4. Backward offsets are supported.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Any other opcode, or opcode 0x00 with any other funct, writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instrAddr | output | 32 | Byte address of the current instruction (program counter) |
| instrData | input | 32 | Instruction word read combinationally from `instrAddr` |
| dataAddr | output | 32 | Byte address of the load or store |
| dataWdata | output | 32 | Store data (rt) |
| dataWe | output | 1 | Data-memory write strobe, high only for stores |
| dataRdata | input | 32 | Load data read combinationally from `dataAddr` |

## Verification
Register contents never appear at the ports. Each result is therefore made visible by a store that follows it. A register that should stay unchanged is preloaded with a known value, then stored after the instruction that must not touch it.

The hardest case to observe is a missing register write. This covers a store that must not write rt, an unknown opcode or funct, and a write aimed at register 0. The stimulus places a known value in the target register, issues the suspect instruction, and then stores that register to a memory word preset to a sentinel.

Branch behaviour is read straight from `instrAddr` one cycle after the compare, for three cases: taken forward, not taken, and taken backward.

// File: rtl/lite_core_pkg.sv
package lite_core_pkg;
  localparam int XLEN      = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = $clog2(REG_COUNT);
  localparam int IMM_W     = 16;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   regDstRd;
    logic   aluSrcImm;
    logic   immZeroExt;
    logic   memWrite;
    logic   memToReg;
    logic   branch;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    rdIdxA,
  input  logic [AW-1:0]    rdIdxB,
  output logic [WIDTH-1:0] rdValA,
  output logic [WIDTH-1:0] rdValB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrIdx,
  input  logic [WIDTH-1:0] wrVal
);
  logic [WIDTH-1:0] regs [DEPTH];

  // Entry 0 is never stored; the other entries are plain enabled registers.
  assign regs[0] = '0;
  for (genvar g = 1; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wrEn && wrIdx == AW'(g)) regs[g] <= wrVal;
    end
  end

  assign rdValA = regs[rdIdxA];
  assign rdValB = regs[rdIdxB];
endmodule

// File: rtl/core_alu.sv
module core_alu
  import lite_core_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluOp_e           op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             isZero
);
  always_comb begin
    unique case (op)
      ALU_SUB: result = a - b;
      ALU_OR:  result = a | b;
      default: result = a + b;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/core_control.sv
module core_control
  import lite_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{default: '0, aluOp: ALU_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADDU) begin
          ctrl.regWrite = 1'b1;
          ctrl.regDstRd = 1'b1;
          ctrl.aluOp    = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.regWrite = 1'b1;
          ctrl.regDstRd = 1'b1;
          ctrl.aluOp    = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.regWrite   = 1'b1;
        ctrl.aluSrcImm  = 1'b1;
        ctrl.immZeroExt = 1'b1;
        ctrl.aluOp      = ALU_OR;
      end
      OP_LW: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      OP_SW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import lite_core_pkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int NREGS = REG_COUNT,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [25:0]      instrLow,
  output logic [WIDTH-1:0] pc,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] memWdata,
  output logic             memWe,
  input  logic [WIDTH-1:0] memRdata
);
  logic [AW-1:0]    rsIdx, rtIdx, rdIdx, wrIdx;
  logic [IMM_W-1:0] imm;
  logic [WIDTH-1:0] pcQ, pcPlus4, pcNext, branchOff;
  logic [WIDTH-1:0] immExt, rsVal, rtVal, aluB, aluRes, wbVal;
  logic             aluZero, takeBranch, wrEn;

  assign rsIdx = instrLow[21 +: AW];
  assign rtIdx = instrLow[16 +: AW];
  assign rdIdx = instrLow[11 +: AW];
  assign imm   = instrLow[IMM_W-1:0];

  // Immediate extenders: zero-padded for the logical op, sign-copied otherwise.
  assign immExt    = ctrl.immZeroExt ? {{(WIDTH-IMM_W){1'b0}}, imm}
                                     : {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
  assign branchOff = {{(WIDTH-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};

  core_regfile #(.WIDTH(WIDTH), .DEPTH(NREGS)) u_rf (
    .clk   (clk),
    .rdIdxA(rsIdx),
    .rdIdxB(rtIdx),
    .rdValA(rsVal),
    .rdValB(rtVal),
    .wrEn  (wrEn),
    .wrIdx (wrIdx),
    .wrVal (wbVal)
  );

  assign aluB = ctrl.aluSrcImm ? immExt : rtVal;

  core_alu #(.WIDTH(WIDTH)) u_alu (
    .op    (ctrl.aluOp),
    .a     (rsVal),
    .b     (aluB),
    .result(aluRes),
    .isZero(aluZero)
  );

  assign wrIdx = ctrl.regDstRd ? rdIdx : rtIdx;
  assign wbVal = ctrl.memToReg ? memRdata : aluRes;
  assign wrEn  = ctrl.regWrite & ~rst;

  // Next-PC selection.
  assign pcPlus4    = pcQ + WIDTH'(4);
  assign takeBranch = ctrl.branch & aluZero;
  assign pcNext     = takeBranch ? (pcPlus4 + branchOff) : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  assign pc       = pcQ;
  assign memAddr  = aluRes;
  assign memWdata = rtVal;
  assign memWe    = ctrl.memWrite & ~rst;
endmodule

// File: rtl/lite_core.sv
module lite_core
  import lite_core_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] instrAddr,
  input  logic [31:0] instrData,
  output logic [31:0] dataAddr,
  output logic [31:0] dataWdata,
  output logic        dataWe,
  input  logic [31:0] dataRdata
);
  ctrl_t ctrl;

  core_control u_ctrl (
    .opcode(instrData[31:26]),
    .funct (instrData[5:0]),
    .ctrl  (ctrl)
  );

  core_datapath #(.WIDTH(XLEN), .NREGS(REG_COUNT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .instrLow(instrData[25:0]),
    .pc      (instrAddr),
    .memAddr (dataAddr),
    .memWdata(dataWdata),
    .memWe   (dataWe),
    .memRdata(dataRdata)
  );
endmodule

// File: rtl/lite_core_chk.sv
module lite_core_chk
  import lite_core_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] instrAddr,
  input logic [5:0]  opcode,
  input logic [15:0] imm,
  input logic        dataWe
);
  logic [31:0] brOff;
  assign brOff = {{14{imm[15]}}, imm, 2'b00};

  // R2
  pc_reset_chk: assert property (@(posedge clk)
    rst |=> (instrAddr == 32'd0));

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode != OP_BEQ) |=> (instrAddr == $past(instrAddr) + 32'd4));

  // R7
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_BEQ) |=> ((instrAddr == $past(instrAddr) + 32'd4) ||
                           (instrAddr == $past(instrAddr) + 32'd4 + $past(brOff))));

  // R6
  store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_SW) |-> dataWe);

  // R9
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dataWe |-> (opcode == OP_SW));
endmodule

bind lite_core lite_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .instrAddr(instrAddr),
  .opcode   (instrData[31:26]),
  .imm      (instrData[15:0]),
  .dataWe   (dataWe)
);

// File: tb/sim_lite_core.sv
`timescale 1ns/1ps
module sim_lite_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrAddr, instrData, dataAddr, dataWdata, dataRdata;
  logic        dataWe;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  lite_core u0 (
    .clk      (clk),
    .rst      (rst),
    .instrAddr(instrAddr),
    .instrData(instrData),
    .dataAddr (dataAddr),
    .dataWdata(dataWdata),
    .dataWe   (dataWe),
    .dataRdata(dataRdata)
  );

  assign instrData = imem[instrAddr[7:2]];
  assign dataRdata = dmem[dataAddr[7:2]];
  always @(posedge clk) if (dataWe) dmem[dataAddr[7:2]] <= dataWdata;

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt,
                                       logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs,
                                       logic [4:0] rt, logic [15:0] k);
    return {op, rs, rt, k};
  endfunction

  task automatic finishUp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      finishUp();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0000_0000;
      dmem[i] = 32'hD00D_0000 + i;
    end
  endtask

  task automatic restart();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    clearMem();
    restart();
    check("R2 pc after reset", instrAddr, 32'd0);
    run(3);
    check("R1 sequential pc", instrAddr, 32'd12);
    rst = 1'b1;
    run(1);
    check("R2 mid-run reset", instrAddr, 32'd0);
    rst = 1'b0;
  endtask

  task automatic testArith();
    clearMem();
    imem[0] = encI(6'h0D, 0, 1, 16'h1234);
    imem[1] = encI(6'h0D, 0, 2, 16'hFFFF);
    imem[2] = encR(1, 2, 3, 6'h21);
    imem[3] = encR(1, 2, 4, 6'h23);
    imem[4] = encI(6'h2B, 0, 3, 16'h0000);
    imem[5] = encI(6'h2B, 0, 4, 16'h0004);
    imem[6] = encI(6'h2B, 0, 2, 16'h0008);
    restart();
    run(7);
    check("R3 addu", dmem[0], 32'h0001_1233);
    check("R3 subu wrap", dmem[1], 32'hFFFF_1235);
    check("R4 ori zero-extend", dmem[2], 32'h0000_FFFF);
  endtask

  task automatic testLoadStore();
    clearMem();
    imem[0] = encI(6'h0D, 0, 5, 16'h0040);
    imem[1] = encI(6'h0D, 0, 6, 16'hBEEF);
    imem[2] = encI(6'h2B, 5, 6, 16'hFFFC);
    imem[3] = encI(6'h23, 5, 7, 16'hFFFC);
    imem[4] = encR(7, 7, 8, 6'h21);
    imem[5] = encI(6'h2B, 5, 8, 16'h0000);
    restart();
    run(6);
    check("R6 store negative offset", dmem[15], 32'h0000_BEEF);
    check("R5 load then add", dmem[16], 32'h0001_7DDE);
    check("R6 neighbour untouched", dmem[17], 32'hD00D_0011);
  endtask

  task automatic testRegZero();
    clearMem();
    imem[0] = encI(6'h0D, 0, 0, 16'h0055);
    imem[1] = encR(0, 0, 9, 6'h21);
    imem[2] = encI(6'h2B, 0, 9, 16'h0050);
    imem[3] = encI(6'h2B, 0, 0, 16'h0054);
    restart();
    run(4);
    check("R8 r0 as operand", dmem[20], 32'd0);
    check("R8 r0 stored", dmem[21], 32'd0);
  endtask

  task automatic testStoreNoWrite();
    clearMem();
    imem[0] = encI(6'h0D, 0, 1, 16'h0077);
    imem[1] = encI(6'h0D, 0, 2, 16'h0080);
    imem[2] = encI(6'h2B, 2, 1, 16'h0000);
    imem[3] = encI(6'h2B, 2, 1, 16'h0004);
    restart();
    run(4);
    check("R6 first store", dmem[32], 32'h0000_0077);
    check("R6 store leaves rt", dmem[33], 32'h0000_0077);
  endtask

  task automatic testUnknown();
    clearMem();
    imem[0] = encI(6'h0D, 0, 1, 16'h0077);
    imem[1] = encI(6'h3F, 0, 1, 16'h1234);
    imem[2] = encR(0, 0, 1, 6'h20);
    imem[3] = encI(6'h2B, 0, 1, 16'h0090);
    restart();
    run(2);
    check("R9 unknown opcode pc", instrAddr, 32'd8);
    run(2);
    check("R9 no register write", dmem[36], 32'h0000_0077);
  endtask

  task automatic testBranch();
    clearMem();
    imem[0] = encI(6'h0D, 0, 1, 16'h0005);
    imem[1] = encI(6'h0D, 0, 2, 16'h0005);
    imem[2] = encI(6'h04, 1, 2, 16'h0002);
    imem[3] = encI(6'h0D, 0, 3, 16'h0BAD);
    imem[4] = encI(6'h0D, 0, 3, 16'h0BAD);
    imem[5] = encI(6'h0D, 0, 3, 16'h600D);
    imem[6] = encI(6'h2B, 0, 3, 16'h0060);
    restart();
    run(3);
    check("R7 taken target", instrAddr, 32'd20);
    run(2);
    check("R7 skipped path", dmem[24], 32'h0000_600D);

    imem[1] = encI(6'h0D, 0, 2, 16'h0006);
    restart();
    run(3);
    check("R7 not taken", instrAddr, 32'd12);

    clearMem();
    imem[2] = encI(6'h04, 0, 0, 16'hFFFE);
    restart();
    run(3);
    check("R7 backward branch", instrAddr, 32'd4);
  endtask

  initial begin
    clearMem();
    testReset();
    testArith();
    testLoadStore();
    testRegZero();
    testStoreNoWrite();
    testUnknown();
    testBranch();
    finishUp();
  end
endmodule